// File: doc/BRIEF.md
# Resumable SHA-1 Hash Engine

This block computes SHA-1 over a message that arrives as 32-bit words written to a register interface. The host may hash a long message in several separate sessions. At the end of a session it reads the five chaining words from the digest registers. It later opens a new session seeded with those words through five IV registers, so the hashing continues where it stopped. Padding and the length field are produced by the host. The engine compresses only whole 512-bit blocks.

A session works like this. The host sets the enable bit in the control register, and the IV-select bit with it if a saved state is to be used. It then streams words into the receive FIFO, respecting the free-slot count in the status register. Next it sets the data-end bit and polls that bit until the engine clears it. Finally it reads the digest and writes zero to the control register.

Each word carries four message bytes; the least significant byte comes first in stream order. The control state machine has five states:

| State | Meaning |
|---|---|
| OFF | Disabled. |
| IDLE | Waiting for a full block or for data-end. |
| LOAD | Pops 16 words into the schedule window, one per clock. |
| ROUND | Runs 80 compression rounds, one per clock. |
| ACCUM | Adds the working variables into the chaining state. |

It has these transitions:
- ENABLE: OFF to IDLE, on an enable write.
- START: IDLE to LOAD, when at least 16 words are queued.
- SCHEDULED: LOAD to ROUND, after the 16th pop.
- COMPRESSED: ROUND to ACCUM, after round 79.
- CHAINED: ACCUM to IDLE.
- FINISH: a self-loop on IDLE. It copies the chaining state to the digest registers and clears data-end.
- ABORT: from any state to OFF, when zero is written to enable.

Top module: `sha1_resume_engine`

Register word addresses, as presented on `reg_addr`:

| Address | Register |
|---|---|
| 0 | Control |
| 1 to 5 | IV0 to IV4 |
| 6 | Data |
| 7 | Status |
| 8 to 12 | Digest 0 to 4 |

## Requirements
- R1: After reset, control (address 0) reads 0, and status (address 7) reads 32 free slots with the overflow bit clear. Control bits [5:4] form a mode field that is stored and read back unchanged. Control bit 0 reads the enable bit, bit 1 the IV-select bit, and bit 2 the data-end bit.
- R2: A control write that raises bit 0 (enable) seeds the chaining state. If bit 1 is 0 in that write, the seed is the standard SHA-1 initial constants. If bit 1 is 1, the seed is IV0..IV4 (addresses 1..5, h0 first). The IV registers read back as written.
- R3: Each group of 16 words written to address 6 forms one block. Byte 0 of a word is its bits [7:0]. After data-end completes, digest registers 8..12 hold h0..h4, the SHA-1 chaining state over all blocks of the session.
- R4: Status bits [5:0] report 32 minus the number of queued words. A control write that raises enable empties the FIFO, so 32 slots are free.
- R5: A word written to address 6 while the engine is disabled or the FIFO is full is dropped, and status bit 31 (overflow) is set. Overflow stays set until the next control write that raises enable.
- R6: Data-end (control bit 2, written together with bit 0) stays set until every whole queued block is compressed. It is cleared when the engine is idle with fewer than 16 words queued. At that point the digest registers are valid, and any leftover partial block is discarded, so status returns to 32 free.
- R7: Writing 0 to control bit 0 aborts any block in progress, empties the FIFO and leaves the digest registers unchanged.
- R8: Suppose the 16th word of a single block is written in cycle 0 and data-end in cycle 1. Data-end then still reads 1 after 98 clock edges counted from cycle 0, and reads 0 after the 99th. A block occupies 16 load, 80 round and 1 accumulate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
Register reads are combinational, so IV, control and status values are sampled on the falling edge just after the rising edge of the write. A pushed word appears in the free count on that same falling edge. Digest results have no fixed sampling cycle in general: the bench polls the data-end bit and reads the digests only once it has cleared. The one fixed-latency case is R8, where the bench counts falling edges exactly: data-end must still read 1 after the 98th edge from the last data word and read 0 after the 99th. Expected digests come from an arithmetic SHA-1 model inside the bench, run over a sweep of block patterns, IV values and session splits.

// File: rtl/sha1_eng_pkg.sv
`timescale 1ns/1ps
package sha1_eng_pkg;
    typedef logic [31:0] word_t;
    typedef logic [4:0][31:0] chain_t;
    typedef enum logic [2:0] {ST_OFF, ST_IDLE, ST_LOAD, ST_ROUND, ST_ACCUM} eng_state_e;

    localparam int RC_W    = 7;
    localparam int A_CTRL  = 0;
    localparam int A_IV0   = 1;
    localparam int A_DATA  = 6;
    localparam int A_STAT  = 7;
    localparam int A_DIG0  = 8;
    localparam int N_CHAIN = 5;

    localparam chain_t H_STD = {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE,
                                32'hEFCDAB89, 32'h67452301};

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic word_t swap_bytes(input word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction
endpackage

// File: rtl/sha1_rx_fifo.sv
`timescale 1ns/1ps
module sha1_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_p, wr_p;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
        end else if (flush) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
        end else begin
            if (push) wr_p <= step(wr_p);
            if (pop)  rd_p <= step(rd_p);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_p] <= din;
    end

    assign dout = mem[rd_p];
endmodule

// File: rtl/sha1_msg_window.sv
`timescale 1ns/1ps
module sha1_msg_window
    import sha1_eng_pkg::*;
#(
    parameter int N = 16
) (
    input  logic  clk,
    input  logic  load_en,
    input  logic  step_en,
    input  word_t load_word,
    output word_t w_now
);
    word_t win [N];
    word_t shift_in;

    always_comb begin
        shift_in = load_en ? load_word
                           : rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
    end

    always_ff @(posedge clk) begin
        if (load_en || step_en) begin
            for (int i = 0; i < N - 1; i++) win[i] <= win[i+1];
            win[N-1] <= shift_in;
        end
    end

    assign w_now = win[0];
endmodule

// File: rtl/sha1_round_step.sv
`timescale 1ns/1ps
module sha1_round_step
    import sha1_eng_pkg::*;
(
    input  logic [RC_W-1:0] idx,
    input  chain_t          cur,
    input  word_t           w,
    output chain_t          nxt
);
    word_t f, k;

    always_comb begin
        if (idx < RC_W'(20)) begin
            f = (cur[1] & cur[2]) | (~cur[1] & cur[3]);
            k = 32'h5A827999;
        end else if (idx < RC_W'(40)) begin
            f = cur[1] ^ cur[2] ^ cur[3];
            k = 32'h6ED9EBA1;
        end else if (idx < RC_W'(60)) begin
            f = (cur[1] & cur[2]) | (cur[1] & cur[3]) | (cur[2] & cur[3]);
            k = 32'h8F1BBCDC;
        end else begin
            f = cur[1] ^ cur[2] ^ cur[3];
            k = 32'hCA62C1D6;
        end
        nxt[0] = rotl(cur[0], 5) + f + cur[4] + k + w;
        nxt[1] = cur[0];
        nxt[2] = rotl(cur[1], 30);
        nxt[3] = cur[2];
        nxt[4] = cur[3];
    end
endmodule

// File: rtl/sha1_resume_engine.sv
`timescale 1ns/1ps
module sha1_resume_engine
    import sha1_eng_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);
    localparam int BLOCK_WORDS = 16;
    localparam int ROUNDS      = 80;
    localparam logic [CNT_W-1:0] BLK_CNT = CNT_W'(BLOCK_WORDS);

    eng_state_e       state_q, state_d;
    logic             en_q, ivsel_q, end_q, ovf_q;
    logic [1:0]       mode_q;
    chain_t           iv_q, h_q, dig_q, work_q, work_nxt;
    logic [RC_W-1:0]  rc_q;
    logic [CNT_W-1:0] fifo_cnt;
    word_t            fifo_dout, w_now;

    logic ctrl_wr, data_wr, en_on, en_off, push, pop, finish, flush;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign data_wr = reg_wr && (reg_addr == ADDR_W'(A_DATA));
    assign en_on   = ctrl_wr && reg_wdata[0] && !en_q;
    assign en_off  = ctrl_wr && !reg_wdata[0];
    assign push    = data_wr && en_q && (fifo_cnt != CNT_W'(FIFO_DEPTH));
    assign pop     = (state_q == ST_LOAD);
    assign finish  = (state_q == ST_IDLE) && end_q && (fifo_cnt < BLK_CNT);
    assign flush   = en_on || en_off || finish;

    sha1_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .din(reg_wdata), .dout(fifo_dout), .count(fifo_cnt)
    );

    sha1_msg_window #(.N(BLOCK_WORDS)) u_window (
        .clk(clk), .load_en(pop), .step_en(state_q == ST_ROUND),
        .load_word(swap_bytes(fifo_dout)), .w_now(w_now)
    );

    sha1_round_step u_round (
        .idx(rc_q), .cur(work_q), .w(w_now), .nxt(work_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (en_off) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   if (en_on) state_d = ST_IDLE;
                ST_IDLE:  if (fifo_cnt >= BLK_CNT) state_d = ST_LOAD;
                ST_LOAD:  if (rc_q == RC_W'(BLOCK_WORDS - 1)) state_d = ST_ROUND;
                ST_ROUND: if (rc_q == RC_W'(ROUNDS - 1)) state_d = ST_ACCUM;
                ST_ACCUM: state_d = ST_IDLE;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // datapath and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ivsel_q <= 1'b0;
            end_q   <= 1'b0;
            ovf_q   <= 1'b0;
            mode_q  <= '0;
            iv_q    <= '0;
            h_q     <= '0;
            dig_q   <= '0;
            work_q  <= '0;
            rc_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q    <= reg_wdata[0];
                ivsel_q <= reg_wdata[1];
                end_q   <= reg_wdata[0] & reg_wdata[2];
                mode_q  <= reg_wdata[5:4];
            end else if (finish) begin
                end_q <= 1'b0;
            end
            for (int i = 0; i < N_CHAIN; i++) begin
                if (reg_wr && reg_addr == ADDR_W'(A_IV0 + i)) iv_q[i] <= reg_wdata;
            end
            if (en_on) ovf_q <= 1'b0;
            else if (data_wr && !push) ovf_q <= 1'b1;

            if (en_on) h_q <= reg_wdata[1] ? iv_q : H_STD;
            else if (state_q == ST_ACCUM) begin
                for (int i = 0; i < N_CHAIN; i++) h_q[i] <= h_q[i] + work_q[i];
            end

            if (finish) dig_q <= h_q;

            if (state_q == ST_IDLE && state_d == ST_LOAD) work_q <= h_q;
            else if (state_q == ST_ROUND) work_q <= work_nxt;

            if (state_d != state_q) rc_q <= '0;
            else if (state_q == ST_LOAD || state_q == ST_ROUND) rc_q <= rc_q + 1'b1;
        end
    end

    // read mux (outputs)
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[0]   = en_q;
            reg_rdata[1]   = ivsel_q;
            reg_rdata[2]   = end_q;
            reg_rdata[5:4] = mode_q;
        end
        if (reg_addr == ADDR_W'(A_STAT)) begin
            reg_rdata[CNT_W-1:0] = CNT_W'(FIFO_DEPTH) - fifo_cnt;
            reg_rdata[31]        = ovf_q;
        end
        for (int i = 0; i < N_CHAIN; i++) begin
            if (reg_addr == ADDR_W'(A_IV0 + i))  reg_rdata = iv_q[i];
            if (reg_addr == ADDR_W'(A_DIG0 + i)) reg_rdata = dig_q[i];
        end
    end
endmodule

// File: rtl/sha1_engine_checks.sv
`timescale 1ns/1ps
module sha1_engine_checks
    import sha1_eng_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input eng_state_e        state,
    input logic [CNT_W-1:0]  cnt,
    input logic              en,
    input logic              end_flag,
    input logic              ovf
);
    logic ctrl_w;
    assign ctrl_w = reg_wr && reg_addr == ADDR_W'(A_CTRL);

    // R7: writing enable low leaves the engine off with an empty FIFO
    a_r7_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && !reg_wdata[0]) |=> (state == ST_OFF && cnt == '0));

    // R4: raising enable empties the FIFO and clears overflow
    a_r4_enable_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && reg_wdata[0] && !en) |=> (cnt == '0 && !ovf));

    // R5: a data write while disabled sets overflow
    a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_DATA) && !en) |=> ovf);

    // R6: data-end only drops while idle with less than a block queued
    a_r6_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && !ctrl_w) |=>
            (end_flag || ($past(state) == ST_IDLE && $past(cnt) < CNT_W'(16))));

    // R3: the schedule load never pops an empty FIFO
    a_r3_load_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (cnt != '0));
endmodule

bind sha1_resume_engine sha1_engine_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .state(state_q), .cnt(fifo_cnt), .en(en_q),
    .end_flag(end_q), .ovf(ovf_q)
);

// File: tb/sha1_resume_engine_test.sv
`timescale 1ns/1ps
module sha1_resume_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [159:0] STD = {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE,
                                    32'hEFCDAB89, 32'h67452301};

    sha1_resume_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [159:0] got, input logic [159:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // reference compression; blk word i as written (byte 0 in bits [7:0])
    function automatic logic [159:0] ref_block(input logic [159:0] h, input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t, x;
        for (int i = 0; i < 16; i++) begin
            x = blk[32*i +: 32];
            w[i] = {x[7:0], x[15:8], x[23:16], x[31:24]};
        end
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = h[31:0]; b = h[63:32]; c = h[95:64]; d = h[127:96]; e = h[159:128];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[159:128] + e, h[127:96] + d, h[95:64] + c, h[63:32] + b, h[31:0] + a};
    endfunction

    function automatic logic [511:0] make_blk(input int seed);
        logic [511:0] r;
        for (int i = 0; i < 16; i++)
            r[32*i +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(i) * 32'h01010101) ^ 32'h5A5AA5A5;
        return r;
    endfunction

    task automatic put(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_word(input logic [31:0] d);
        logic [31:0] s;
        rd(4'd7, s);
        while (s[5:0] == 6'd0) rd(4'd7, s);
        put(4'd6, d);
        idle();
    endtask

    task automatic read_digest(output logic [159:0] dg);
        logic [31:0] v;
        for (int i = 0; i < 5; i++) begin
            rd(4'(8 + i), v);
            dg[32*i +: 32] = v;
        end
    endtask

    task automatic wait_end(input string req);
        logic [31:0] v;
        int n = 0;
        rd(4'd0, v);
        while (v[2] && n < 2000) begin rd(4'd0, v); n++; end
        chk(req, {159'd0, v[2]}, 160'd0);
    endtask

    task automatic session(input bit use_iv, input logic [159:0] iv, input int nblk,
                           input int seed, input int extra, output logic [159:0] dg);
        logic [511:0] blk;
        if (use_iv) for (int i = 0; i < 5; i++) begin put(4'(1 + i), iv[32*i +: 32]); idle(); end
        put(4'd0, use_iv ? 32'h3 : 32'h1); idle();
        for (int b = 0; b < nblk; b++) begin
            blk = make_blk(seed + b);
            for (int i = 0; i < 16; i++) push_word(blk[32*i +: 32]);
        end
        for (int i = 0; i < extra; i++) push_word(32'hDEAD0000 + 32'(i));
        put(4'd0, 32'h5); idle();
        wait_end("R6");
        read_digest(dg);
        put(4'd0, 32'h0); idle();
    endtask

    initial begin
        logic [31:0]  v;
        logic [159:0] dg, d1, exp, ivv;
        logic [511:0] abc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", {128'd0, v}, 160'd0);
        rd(4'd7, v); chk("R1 status", {128'd0, v}, 160'd32);
        read_digest(dg); chk("R1 digest", dg, 160'd0);

        // R1 mode field readback
        put(4'd0, 32'h21); idle();
        rd(4'd0, v); chk("R1 mode", {128'd0, v}, 160'h21);
        put(4'd0, 32'h0); idle();

        // R3 known vector "abc" with standard seed
        abc = '0;
        abc[31:0]    = 32'h80636261;
        abc[511:480] = 32'h18000000;
        chk("R3 model", ref_block(STD, abc),
            {32'h9CD0D89D, 32'h7850C26C, 32'hBA3E2571, 32'h4706816A, 32'hA9993E36});
        put(4'd0, 32'h1); idle();
        for (int i = 0; i < 16; i++) push_word(abc[32*i +: 32]);
        put(4'd0, 32'h5); idle();
        wait_end("R6 abc");
        read_digest(dg);
        chk("R3 abc", dg, {32'h9CD0D89D, 32'h7850C26C, 32'hBA3E2571, 32'h4706816A, 32'hA9993E36});
        put(4'd0, 32'h0); idle();

        // R3 sweep of single and multi-block sessions
        for (int s = 1; s <= 6; s++) begin
            session(1'b0, '0, 1, s * 7, 0, dg);
            chk("R3 sweep1", dg, ref_block(STD, make_blk(s * 7)));
        end
        for (int n = 2; n <= 3; n++) begin
            session(1'b0, '0, n, 100 + n, 0, dg);
            exp = STD;
            for (int b = 0; b < n; b++) exp = ref_block(exp, make_blk(100 + n + b));
            chk("R3 multi", dg, exp);
        end

        // R2 split across two sessions
        session(1'b0, '0, 1, 40, 0, d1);
        session(1'b1, d1, 1, 41, 0, dg);
        chk("R2 resume", dg, ref_block(ref_block(STD, make_blk(40)), make_blk(41)));
        for (int i = 0; i < 5; i++) begin
            rd(4'(1 + i), v); chk("R2 iv readback", {128'd0, v}, {128'd0, d1[32*i +: 32]});
        end

        // R2 arbitrary seeds sweep
        for (int s = 0; s < 3; s++) begin
            ivv = {5{32'h13579BDF * 32'(s + 3)}} ^ 160'h0123456789ABCDEF0011223344556677DEADBEEF;
            session(1'b1, ivv, 1, 60 + s, 0, dg);
            chk("R2 seed", dg, ref_block(ivv, make_blk(60 + s)));
        end

        // R2 IV loaded but select clear: standard constants
        session(1'b0, '0, 1, 70, 0, dg);
        chk("R2 std", dg, ref_block(STD, make_blk(70)));

        // R6 leftover partial words discarded
        session(1'b0, '0, 1, 80, 3, dg);
        chk("R6 partial", dg, ref_block(STD, make_blk(80)));
        put(4'd0, 32'h1); idle();
        put(4'd0, 32'h5); idle();
        rd(4'd7, v); chk("R6 free", {128'd0, v}, 160'd32);
        put(4'd0, 32'h0); idle();

        // R4 free count
        put(4'd0, 32'h1); idle();
        for (int i = 0; i < 5; i++) push_word(32'(i));
        rd(4'd7, v); chk("R4 free5", {128'd0, v}, 160'd27);
        for (int i = 0; i < 10; i++) push_word(32'(i));
        rd(4'd7, v); chk("R4 free15", {128'd0, v}, 160'd17);
        put(4'd0, 32'h0); idle();

        // R5 drop while disabled, cleared by enable
        put(4'd6, 32'h12345678); idle();
        rd(4'd7, v); chk("R5 ovf off", {128'd0, v}, {128'd0, 32'h80000020});
        put(4'd0, 32'h1); idle();
        rd(4'd7, v); chk("R4 enable", {128'd0, v}, 160'd32);
        // R5 overflow when full: unthrottled burst
        for (int i = 0; i < 64; i++) put(4'd6, 32'(i));
        idle();
        rd(4'd7, v); chk("R5 ovf full", {159'd0, v[31]}, 160'd1);
        put(4'd0, 32'h0); idle();

        // R7 abort mid-block keeps digest
        session(1'b0, '0, 1, 90, 0, d1);
        put(4'd0, 32'h1); idle();
        for (int i = 0; i < 16; i++) push_word(32'hA0A0A0A0 ^ 32'(i));
        repeat (30) @(negedge clk);
        put(4'd0, 32'h0); idle();
        rd(4'd7, v); chk("R7 flush", {128'd0, v}, 160'd32);
        rd(4'd0, v); chk("R7 ctrl", {128'd0, v}, 160'd0);
        read_digest(dg); chk("R7 digest kept", dg, d1);
        session(1'b0, '0, 1, 91, 0, dg);
        chk("R7 fresh", dg, ref_block(STD, make_blk(91)));

        // R8 exact latency
        put(4'd0, 32'h1); idle();
        abc = make_blk(95);
        for (int i = 0; i < 16; i++) put(4'd6, abc[32*i +: 32]);
        put(4'd0, 32'h5);
        @(negedge clk); reg_wr = 1'b0; reg_addr = 4'd0;
        #1 chk("R8 set", {159'd0, reg_rdata[2]}, 160'd1);
        repeat (97) @(negedge clk);
        #1 chk("R8 busy", {159'd0, reg_rdata[2]}, 160'd1);
        @(negedge clk);
        #1 chk("R8 clear", {159'd0, reg_rdata[2]}, 160'd0);
        read_digest(dg); chk("R8 digest", dg, ref_block(STD, abc));
        put(4'd0, 32'h0); idle();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule